// File: doc/BRIEF.md
# Bidirectional GPIO Port with Analog and Peripheral Pin Sharing

This block is an 8-bit general-purpose I/O port with a small register-mapped bus interface. It holds an output latch, a per-bit direction register and a 4-bit analog-configuration field. From these it drives the tri-state controls of eight pads (an output value and an output enable per pin), and it samples the pad levels through a synchronizer.

The four low pins can be handed to an external analog converter. The configuration field chooses how many of them stay digital. The upper four pins are shared with peripherals:

- pin 4 feeds a capture input;
- pin 5 can carry a PWM output;
- pins 6 and 7 carry the transmit and receive lines of a two-wire serial port.

A peripheral that is enabled takes over its pin regardless of the direction register. Software programs the port by writing the latch before it opens the output drivers. Reads of the data address show the levels on the pins, not the contents of the latch.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset the direction register reads 0xFF, every pad_oe bit is 0, the output latch is 0 and the analog-configuration field reads 0. With that field at 0, all four low pins are analog.
- R2: For a digital pin that no peripheral overrides, a direction bit of 1 makes the pin an input (pad_oe 0) and a direction bit of 0 makes it an output (pad_oe 1).
- R3: A bus write to address 0 changes only the output latch, one clock after the write. pad_out shows the latch bits on every pin that is not overridden. The direction register and the configuration field do not change.
- R4: A read of address 0 returns the synchronized pin levels, not the latch. Any low pin in analog mode reads as 0.
- R5: A change on pad_in becomes visible on reads, on cap_in and on ser_rx after exactly two rising clock edges, and not after one.
- R6: Readback depends on the address:
  - address 1 returns the direction register;
  - address 2 returns the configuration field in bits 3:0, with zeros above;
  - address 3 always reads 0.
  A write to address 3 has no effect on any state.
- R7: Low pin i (i = 0..3) is analog when i is greater than or equal to the 4-bit configuration value. A value of 0x0E therefore makes all four digital. ana_sel carries this mask, and an analog pin has pad_oe 0.
- R8: cap_in equals the synchronized level of pin 4, and ser_rx equals the synchronized level of pin 7.
- R9: While pwm_en is 1, pin 5 has pad_oe 1 and pad_out[5] equals pwm_out, whatever its direction and latch bits hold.
- R10: While ser_en is 1, pin 6 has pad_oe 1 with pad_out[6] equal to ser_tx, and pin 7 has pad_oe 0, whatever the direction bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 analog config |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 8 | Levels sampled from the pads |
| pad_out | output | 8 | Output value driven to the pads |
| pad_oe | output | 8 | Output-enable per pad (1 = drive) |
| ana_sel | output | 4 | Low pins currently in analog mode |
| cap_in | output | 1 | Synchronized pin 4 for the capture unit |
| pwm_en | input | 1 | PWM owns pin 5 |
| pwm_out | input | 1 | PWM level for pin 5 |
| ser_en | input | 1 | Serial port owns pins 6 and 7 |
| ser_tx | input | 1 | Serial transmit level for pin 6 |
| ser_rx | output | 1 | Synchronized pin 7 for the serial receiver |

## Verification
The bench builds the port with its default parameters: eight pins, four analog-capable pins and a two-stage synchronizer. With these values every configuration code from 0 to 15 reaches a distinct analog mask or the all-digital case. The two-edge latency of the inputs is measured directly. Random traffic mixes writes to the data, direction, configuration and unused addresses with random peripheral enables, so overrides collide with the direction and latch settings.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;

    localparam int PORT_W  = 8;
    localparam int ANA_W   = 4;
    localparam int CFG_W   = 4;
    localparam int ADDR_W  = 2;

    localparam int CAP_BIT = 4;
    localparam int PWM_BIT = 5;
    localparam int TX_BIT  = 6;
    localparam int RX_BIT  = 7;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DATA = 2'd0,
        ADR_DIR  = 2'd1,
        ADR_ACFG = 2'd2,
        ADR_NONE = 2'd3
    } port_addr_e;

    typedef struct packed {
        logic [PORT_W-1:0] latch;
        logic [PORT_W-1:0] dir;
        logic [CFG_W-1:0]  acfg;
    } port_state_t;

    typedef struct packed {
        logic pwm_en;
        logic pwm_val;
        logic ser_en;
        logic ser_tx;
    } periph_ovr_t;

    // Low pin i is analog when i >= configuration value.
    function automatic logic [ANA_W-1:0] analog_mask(input logic [CFG_W-1:0] cfg);
        logic [ANA_W-1:0] m;
        for (int i = 0; i < ANA_W; i++) begin
            m[i] = (i >= int'(cfg));
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_mux_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr,
    input  port_addr_e              addr,
    input  logic [PORT_W-1:0]       wdata,
    output port_state_t             st
);

    port_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.latch <= '0;
            st_q.dir   <= '1;
            st_q.acfg  <= '0;
        end else if (wr) begin
            unique case (addr)
                ADR_DATA: st_q.latch <= wdata;
                ADR_DIR:  st_q.dir   <= wdata;
                ADR_ACFG: st_q.acfg  <= wdata[CFG_W-1:0];
                default:  ;
            endcase
        end
    end

    assign st = st_q;

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_padmux.sv
module gpio_padmux
    import gpio_mux_pkg::*;
(
    input  port_state_t        st,
    input  periph_ovr_t        ovr,
    output logic [PORT_W-1:0]  pad_out,
    output logic [PORT_W-1:0]  pad_oe,
    output logic [ANA_W-1:0]   ana_sel
);

    logic [ANA_W-1:0] amask;

    assign amask   = analog_mask(st.acfg);
    assign ana_sel = amask;

    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (i < ANA_W) begin : g_ana
            assign pad_out[i] = st.latch[i];
            assign pad_oe[i]  = ~amask[i] & ~st.dir[i];
        end else if (i == PWM_BIT) begin : g_pwm
            assign pad_out[i] = ovr.pwm_en ? ovr.pwm_val : st.latch[i];
            assign pad_oe[i]  = ovr.pwm_en | ~st.dir[i];
        end else if (i == TX_BIT) begin : g_tx
            assign pad_out[i] = ovr.ser_en ? ovr.ser_tx : st.latch[i];
            assign pad_oe[i]  = ovr.ser_en | ~st.dir[i];
        end else if (i == RX_BIT) begin : g_rx
            assign pad_out[i] = st.latch[i];
            assign pad_oe[i]  = ~ovr.ser_en & ~st.dir[i];
        end else begin : g_plain
            assign pad_out[i] = st.latch[i];
            assign pad_oe[i]  = ~st.dir[i];
        end
    end

endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
    import gpio_mux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        pad_in,
    output logic [7:0]        pad_out,
    output logic [7:0]        pad_oe,
    output logic [3:0]        ana_sel,
    output logic              cap_in,
    input  logic              pwm_en,
    input  logic              pwm_out,
    input  logic              ser_en,
    input  logic              ser_tx,
    output logic              ser_rx
);

    localparam int PAD_HI = PORT_W - ANA_W;

    port_state_t       st;
    periph_ovr_t       ovr;
    port_addr_e        addr_e;
    logic [PORT_W-1:0] pins_s;
    logic [ANA_W-1:0]  amask;

    assign addr_e = port_addr_e'(bus_addr);

    gpio_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (addr_e),
        .wdata (bus_wdata),
        .st    (st)
    );

    gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_s)
    );

    assign ovr.pwm_en  = pwm_en;
    assign ovr.pwm_val = pwm_out;
    assign ovr.ser_en  = ser_en;
    assign ovr.ser_tx  = ser_tx;

    gpio_padmux u_mux (
        .st      (st),
        .ovr     (ovr),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .ana_sel (amask)
    );

    assign ana_sel = amask;
    assign cap_in  = pins_s[CAP_BIT];
    assign ser_rx  = pins_s[RX_BIT];

    always_comb begin
        unique case (addr_e)
            ADR_DATA: bus_rdata = pins_s & {{PAD_HI{1'b1}}, ~amask};
            ADR_DIR:  bus_rdata = st.dir;
            ADR_ACFG: bus_rdata = {{(PORT_W-CFG_W){1'b0}}, st.acfg};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] pad_in,
    input logic [7:0] pad_out,
    input logic [7:0] pad_oe,
    input logic [3:0] ana_sel,
    input logic       cap_in,
    input logic       pwm_en,
    input logic       pwm_out,
    input logic       ser_en,
    input logic       ser_tx,
    input logic       ser_rx
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_RESET_NO_DRIVE: assert property (@(posedge clk)
        $fell(rst) |-> (pad_oe == 8'h00 && ana_sel == 4'hF)); // R1

    AST_DATA_WRITE_LATCH: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd0) |=> (pad_out[4:0] == $past(bus_wdata[4:0]))); // R3

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd1) |=> (pad_oe[4] == !$past(bus_wdata[4]))); // R2

    AST_ANALOG_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (ana_sel & pad_oe[3:0]) == 4'h0); // R7

    AST_PWM_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        pwm_en |-> (pad_oe[5] && pad_out[5] == pwm_out)); // R9

    AST_SERIAL_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        ser_en |-> (pad_oe[6] && !pad_oe[7] && pad_out[6] == ser_tx)); // R10

    AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (cap_in == $past(pad_in[4], 2)
                                 && ser_rx == $past(pad_in[7], 2))); // R5

endmodule

bind gpio_port_mux gpio_mux_chk u_chk (.*);

// File: tb/tb_gpio_port_mux.sv
module tb_gpio_port_mux;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [3:0] ana_sel;
    logic       cap_in;
    logic       pwm_en, pwm_out, ser_en, ser_tx;
    logic       ser_rx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_latch, m_dir;
    logic [3:0] m_cfg;

    always #5 clk = ~clk;

    gpio_port_mux dut (.*);

    function automatic logic [3:0] f_ana(input logic [3:0] c);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) m[i] = (i >= int'(c));
        return m;
    endfunction

    function automatic logic [7:0] f_oe(input logic [7:0] d, input logic [3:0] c,
                                        input logic pe, input logic se);
        logic [7:0] o;
        logic [3:0] a;
        a = f_ana(c);
        for (int i = 0; i < 8; i++) begin
            if (i < 4 && a[i])       o[i] = 1'b0;
            else if (i == 5 && pe)   o[i] = 1'b1;
            else if (i == 6 && se)   o[i] = 1'b1;
            else if (i == 7 && se)   o[i] = 1'b0;
            else                     o[i] = ~d[i];
        end
        return o;
    endfunction

    function automatic logic [7:0] f_out(input logic [7:0] l, input logic pe, input logic pv,
                                         input logic se, input logic tx);
        logic [7:0] o;
        o = l;
        if (pe) o[5] = pv;
        if (se) o[6] = tx;
        return o;
    endfunction

    function automatic logic [7:0] f_read(input logic [7:0] p, input logic [3:0] c);
        return p & {4'hF, ~f_ana(c)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_latch = d;
        else if (a == 2'd1) m_dir = d;
        else if (a == 2'd2) m_cfg = d[3:0];
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
        pad_in = 8'h00; pwm_en = 0; pwm_out = 0; ser_en = 0; ser_tx = 0;
        m_latch = 8'h00; m_dir = 8'hFF; m_cfg = 4'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 ana_sel", ana_sel, 4'hF);
        bus_read(2'd1, rd); chk("R1 dir", rd, 8'hFF);
        bus_read(2'd2, rd); chk("R1 acfg", rd, 8'h00);

        // R7 all digital with 0x0E; R2 outputs
        bus_write(2'd2, 8'h0E);
        chk("R7 digital ana_sel", ana_sel, 4'h0);
        bus_write(2'd0, 8'hA5);
        bus_write(2'd1, 8'h00);
        chk("R2 all outputs", pad_oe, 8'hFF);
        chk("R3 latch to pad", pad_out, 8'hA5);
        bus_read(2'd2, rd); chk("R3 cfg untouched", rd, 8'h0E);

        // R4 read returns pins, not latch
        pad_in = 8'h3C;
        repeat (2) @(negedge clk);
        bus_read(2'd0, rd); chk("R4 pin read", rd, 8'h3C);

        // R5 two-edge latency
        pad_in = 8'hC3;
        @(negedge clk);
        bus_read(2'd0, rd); chk("R5 one edge old", rd, 8'h3C);
        @(negedge clk);
        bus_read(2'd0, rd); chk("R5 two edges new", rd, 8'hC3);
        chk("R8 ser_rx", ser_rx, 1'b1);
        chk("R8 cap_in", cap_in, 1'b0);

        // R6 address 3
        bus_write(2'd3, 8'h5A);
        bus_read(2'd3, rd); chk("R6 addr3 reads 0", rd, 8'h00);
        chk("R6 addr3 write ignored out", pad_out, 8'hA5);
        chk("R6 addr3 write ignored oe", pad_oe, 8'hFF);

        // R7 partial analog: cfg 2 -> pins 2,3 analog
        bus_write(2'd2, 8'h02);
        chk("R7 ana_sel cfg2", ana_sel, 4'hC);
        chk("R7 oe cfg2", pad_oe, 8'hF3);
        pad_in = 8'hFF;
        repeat (2) @(negedge clk);
        bus_read(2'd0, rd); chk("R4 analog reads 0", rd, 8'hF3);

        // R9/R10 override against dir=input
        bus_write(2'd1, 8'hFF);
        pwm_en = 1; pwm_out = 1; ser_en = 1; ser_tx = 0;
        #1;
        chk("R9 pwm oe/out", {pad_oe[5], pad_out[5]}, 2'b11);
        chk("R10 tx oe/out", {pad_oe[6], pad_out[6]}, 2'b10);
        bus_write(2'd1, 8'h00);
        chk("R10 rx forced input", pad_oe[7], 1'b0);
        pwm_en = 0; ser_en = 0;

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [1:0] a;
            logic [7:0] d;
            @(negedge clk);
            pad_in  = 8'($urandom);
            pwm_en  = 1'($urandom); pwm_out = 1'($urandom);
            ser_en  = 1'($urandom); ser_tx  = 1'($urandom);
            a = 2'($urandom);
            d = 8'($urandom);
            bus_addr = a; bus_wdata = d; bus_wr = ($urandom % 4) != 0;
            @(negedge clk);
            if (bus_wr) begin
                if (a == 2'd0) m_latch = d;
                else if (a == 2'd1) m_dir = d;
                else if (a == 2'd2) m_cfg = d[3:0];
            end
            bus_wr = 1'b0;
            #1;
            chk("R2 R9 R10 oe", pad_oe, f_oe(m_dir, m_cfg, pwm_en, ser_en));
            chk("R3 out", pad_out, f_out(m_latch, pwm_en, pwm_out, ser_en, ser_tx));
            chk("R7 ana_sel", ana_sel, f_ana(m_cfg));
            @(negedge clk);
            bus_read(2'd0, rd); chk("R4 read", rd, f_read(pad_in, m_cfg));
            chk("R8 cap_in", cap_in, pad_in[4]);
            chk("R8 ser_rx", ser_rx, pad_in[7]);
            bus_read(2'd1, rd); chk("R6 dir", rd, m_dir);
            bus_read(2'd2, rd); chk("R6 acfg", rd, {4'h0, m_cfg});
        end

        report();
    end

endmodule